// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block steps through a 128-word control store. It holds the current control address, which drives the control memory, and a single-entry return register for microcode subroutines. Each clock edge it picks the next control address from the current microinstruction's branch-kind field, condition-select field and branch-target field. It uses three datapath status bits (indirect flag, accumulator sign, accumulator zero) and the 4-bit opcode of the current instruction word.

The four branch kinds are conditional jump, conditional call, return and opcode dispatch. A jump or a call whose condition is true goes to the target field; otherwise the address steps by one. A taken call also saves the following address as the return point. Return reloads the saved point. Dispatch sends each opcode to its own 4-word routine slot in the lower half of the store. Reset places the sequencer on the first fetch microinstruction at address 64.

All pins are plain control and status signals. The block advances on every clock and has no handshake.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low, `car` is 64 and the return register is 0. A return issued as the first step after reset therefore yields `car` = 0.
- R2: The condition select `cond_sel` encodes 00 = always true, 01 = `ind_bit`, 10 = `sign_bit`, 11 = `zero_bit`.
- R3: With `br_kind` = 00 (jump) and the selected condition true, `car` equals `br_addr` after the edge.
- R4: With `br_kind` = 00 (jump) or 01 (call) and the selected condition false, `car` becomes `car`+1 after the edge.
- R5: With `br_kind` = 01 (call) and the condition true, `car` becomes `br_addr`. In the same edge the return register takes the old `car`+1, modulo 128.
- R6: With `br_kind` = 10 (return), `car` becomes the return register's value, whatever `cond_sel` and `br_addr` hold.
- R7: With `br_kind` = 11 (dispatch), `car` becomes {0, `opcode`[3:0], 00}, for example opcode 0010 gives 8. `cond_sel`, `br_addr` and the status bits have no effect.
- R8: The return register changes only on a call whose condition is true. Jumps, returns, dispatches and untaken calls leave it unchanged.
- R9: Stepping by one from address 127 gives address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cond_sel | input | 2 | Condition select of the current microinstruction |
| br_kind | input | 2 | Branch kind: 00 jump, 01 call, 10 return, 11 dispatch |
| br_addr | input | 7 | Branch target field |
| ind_bit | input | 1 | Indirect-address flag from the instruction word |
| sign_bit | input | 1 | Accumulator sign bit |
| zero_bit | input | 1 | Accumulator-is-zero flag |
| opcode | input | 4 | Instruction opcode used by dispatch |
| car | output | 7 | Control address to the control memory |

## Verification
A taken call does two things in the same edge: it redirects the control address to the target and it writes the return register with the old address plus one. The bench provokes this case with directed calls issued from address 127, where the saved point has to wrap to 0. It also issues random calls from arbitrary addresses. It judges the saved value only through a later return, which must land on exactly that point, and an untaken call in between must not disturb it.

// File: rtl/useq_pkg.sv
package useq_pkg;
  localparam int unsigned CS_ADDR_W = 7;
  localparam int unsigned OPC_W     = 4;
  localparam int unsigned SLOT_LSB  = 2;
  localparam int unsigned BOOT_ADDR = 64;

  typedef enum logic [1:0] {
    BK_JUMP     = 2'b00,
    BK_CALL     = 2'b01,
    BK_RETURN   = 2'b10,
    BK_DISPATCH = 2'b11
  } br_kind_e;

  typedef enum logic [1:0] {
    CS_ALWAYS = 2'b00,
    CS_IND    = 2'b01,
    CS_SIGN   = 2'b10,
    CS_ZERO   = 2'b11
  } cond_sel_e;
endpackage

// File: rtl/useq_cond_sel.sv
module useq_cond_sel
  import useq_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       ind_bit,
  input  logic       sign_bit,
  input  logic       zero_bit,
  output logic       hit
);
  logic [3:0] flags;

  assign flags[CS_ALWAYS] = 1'b1;
  assign flags[CS_IND]    = ind_bit;
  assign flags[CS_SIGN]   = sign_bit;
  assign flags[CS_ZERO]   = zero_bit;

  assign hit = flags[sel];
endmodule

// File: rtl/useq_map.sv
module useq_map #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned LSB_Z  = 2
) (
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] slot_addr
);
  localparam int unsigned TOP_PAD = ADDR_W - OP_W - LSB_Z;

  generate
    if (TOP_PAD > 0) begin : g_pad
      assign slot_addr = {{TOP_PAD{1'b0}}, opcode, {LSB_Z{1'b0}}};
    end else begin : g_nopad
      assign slot_addr = {opcode, {LSB_Z{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [ADDR_W-1:0] ret_addr,
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] target,
  input  logic              hit,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic [ADDR_W-1:0] nxt_addr,
  output logic              save_en,
  output logic [ADDR_W-1:0] save_addr
);
  logic [ADDR_W-1:0] seq_addr;
  br_kind_e          bk;

  assign seq_addr  = cur_addr + ADDR_W'(1);
  assign bk        = br_kind_e'(kind);
  assign save_addr = seq_addr;

  always_comb begin
    save_en  = 1'b0;
    nxt_addr = seq_addr;
    case (bk)
      BK_JUMP:     nxt_addr = hit ? target : seq_addr;
      BK_CALL: begin
        nxt_addr = hit ? target : seq_addr;
        save_en  = hit;
      end
      BK_RETURN:   nxt_addr = ret_addr;
      BK_DISPATCH: nxt_addr = slot_addr;
      default:     nxt_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int unsigned ADDR_W   = CS_ADDR_W,
  parameter int unsigned OP_W     = OPC_W,
  parameter int unsigned LSB_Z    = SLOT_LSB,
  parameter int unsigned RST_ADDR = BOOT_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cond_sel,
  input  logic [1:0]        br_kind,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              ind_bit,
  input  logic              sign_bit,
  input  logic              zero_bit,
  input  logic [OP_W-1:0]   opcode,
  output logic [ADDR_W-1:0] car
);
  localparam logic [ADDR_W-1:0] RST_VAL = ADDR_W'(RST_ADDR);

  logic [ADDR_W-1:0] car_q;
  logic [ADDR_W-1:0] sbr_q;
  logic [ADDR_W-1:0] car_d;
  logic [ADDR_W-1:0] slot_addr;
  logic [ADDR_W-1:0] save_addr;
  logic              hit;
  logic              save_en;

  useq_cond_sel u_cond (
    .sel      (cond_sel),
    .ind_bit  (ind_bit),
    .sign_bit (sign_bit),
    .zero_bit (zero_bit),
    .hit      (hit)
  );

  useq_map #(
    .ADDR_W (ADDR_W),
    .OP_W   (OP_W),
    .LSB_Z  (LSB_Z)
  ) u_map (
    .opcode    (opcode),
    .slot_addr (slot_addr)
  );

  useq_next_addr #(
    .ADDR_W (ADDR_W)
  ) u_next (
    .cur_addr  (car_q),
    .ret_addr  (sbr_q),
    .kind      (br_kind),
    .target    (br_addr),
    .hit       (hit),
    .slot_addr (slot_addr),
    .nxt_addr  (car_d),
    .save_en   (save_en),
    .save_addr (save_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_q <= RST_VAL;
    end else begin
      car_q <= car_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sbr_q <= '0;
    end else if (save_en) begin
      sbr_q <= save_addr;
    end
  end

  assign car = car_q;
endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int unsigned ADDR_W   = 7,
  parameter int unsigned OP_W     = 4,
  parameter int unsigned LSB_Z    = 2,
  parameter int unsigned RST_ADDR = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        cond_sel,
  input logic [1:0]        br_kind,
  input logic [ADDR_W-1:0] br_addr,
  input logic              ind_bit,
  input logic              sign_bit,
  input logic              zero_bit,
  input logic [OP_W-1:0]   opcode,
  input logic [ADDR_W-1:0] car,
  input logic [ADDR_W-1:0] sbr
);
  logic              c_hit;
  logic [ADDR_W-1:0] c_inc;
  logic [ADDR_W-1:0] c_slot;

  always_comb begin
    case (cond_sel)
      2'b00:   c_hit = 1'b1;
      2'b01:   c_hit = ind_bit;
      2'b10:   c_hit = sign_bit;
      default: c_hit = zero_bit;
    endcase
  end

  assign c_inc  = car + ADDR_W'(1);
  assign c_slot = ADDR_W'({opcode, {LSB_Z{1'b0}}});

  a_r1_reset_addr: assert property (@(posedge clk)
    !rst_n |=> (car == ADDR_W'(RST_ADDR)) && (sbr == '0));

  a_r3_jump_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b00 && c_hit) |=> car == $past(br_addr));

  a_r4_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind[1] == 1'b0 && !c_hit) |=> car == $past(c_inc));

  a_r5_call_save: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b01 && c_hit) |=> (sbr == $past(c_inc)) && (car == $past(br_addr)));

  a_r6_return: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b10) |=> car == $past(sbr));

  a_r7_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'b11) |=> car == $past(c_slot));

  a_r8_sbr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_kind == 2'b01 && c_hit) |=> $stable(sbr));
endmodule

bind useq_sequencer useq_sequencer_chk #(
  .ADDR_W   (ADDR_W),
  .OP_W     (OP_W),
  .LSB_Z    (LSB_Z),
  .RST_ADDR (RST_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cond_sel (cond_sel),
  .br_kind  (br_kind),
  .br_addr  (br_addr),
  .ind_bit  (ind_bit),
  .sign_bit (sign_bit),
  .zero_bit (zero_bit),
  .opcode   (opcode),
  .car      (car),
  .sbr      (sbr_q)
);

// File: tb/sim_useq_sequencer.sv
module sim_useq_sequencer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cond_sel = '0;
  logic [1:0] br_kind = '0;
  logic [6:0] br_addr = '0;
  logic       ind_bit = 1'b0;
  logic       sign_bit = 1'b0;
  logic       zero_bit = 1'b0;
  logic [3:0] opcode = '0;
  logic [6:0] car;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [6:0] m_car;
  logic [6:0] m_sbr;

  always #10 clk = ~clk;

  useq_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .cond_sel(cond_sel), .br_kind(br_kind),
    .br_addr(br_addr), .ind_bit(ind_bit), .sign_bit(sign_bit),
    .zero_bit(zero_bit), .opcode(opcode), .car(car)
  );

  function automatic bit f_cond(input logic [1:0] cs, input bit i, input bit s, input bit z);
    case (cs)
      2'b00:   return 1'b1;
      2'b01:   return i;
      2'b10:   return s;
      default: return z;
    endcase
  endfunction

  function automatic string f_tag(input logic [1:0] bk, input bit c);
    case (bk)
      2'b00:   return c ? "R3" : "R4";
      2'b01:   return c ? "R5" : "R4";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string tag, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s car=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive, let one edge pass, check at the next negedge.
  task automatic step(input logic [1:0] cs, input logic [1:0] bk, input logic [6:0] ad,
                      input bit i, input bit s, input bit z, input logic [3:0] op,
                      input string tag_in);
    bit c;
    logic [6:0] e_car;
    logic [6:0] e_sbr;
    string tag;
    cond_sel = cs; br_kind = bk; br_addr = ad;
    ind_bit = i; sign_bit = s; zero_bit = z; opcode = op;
    c = f_cond(cs, i, s, z);
    e_sbr = m_sbr;
    case (bk)
      2'b00: e_car = c ? ad : m_car + 7'd1;
      2'b01: begin
        e_car = c ? ad : m_car + 7'd1;
        if (c) e_sbr = m_car + 7'd1;
      end
      2'b10: e_car = m_sbr;
      default: e_car = {1'b0, op, 2'b00};
    endcase
    tag = (tag_in == "") ? f_tag(bk, c) : tag_in;
    @(posedge clk);
    @(negedge clk);
    check(tag, car, e_car);
    m_car = e_car;
    m_sbr = e_sbr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1", car, 7'd64);
    rst_n = 1'b1;
    m_car = 7'd64;
    m_sbr = 7'd0;
    // R1: cleared return register seen through an immediate return
    step(2'b01, 2'b10, 7'd99, 1'b1, 1'b0, 1'b0, 4'h0, "R1");
    // R2: each select with its flag true, then false
    step(2'b00, 2'b00, 7'd10, 1'b0, 1'b0, 1'b0, 4'h0, "R2");
    step(2'b01, 2'b00, 7'd20, 1'b1, 1'b0, 1'b0, 4'h0, "R2");
    step(2'b01, 2'b00, 7'd30, 1'b0, 1'b1, 1'b1, 4'h0, "R2");
    step(2'b10, 2'b00, 7'd40, 1'b0, 1'b1, 1'b0, 4'h0, "R2");
    step(2'b10, 2'b00, 7'd50, 1'b1, 1'b0, 1'b1, 4'h0, "R2");
    step(2'b11, 2'b00, 7'd60, 1'b0, 1'b0, 1'b1, 4'h0, "R2");
    step(2'b11, 2'b00, 7'd70, 1'b1, 1'b1, 1'b0, 4'h0, "R2");
    // R9: step from 127 wraps to 0
    step(2'b00, 2'b00, 7'd127, 1'b0, 1'b0, 1'b0, 4'h0, "R3");
    step(2'b01, 2'b01, 7'd33, 1'b0, 1'b0, 1'b0, 4'h0, "R9");
    // R5: taken call from 127 saves wrapped 0, return lands there
    step(2'b00, 2'b00, 7'd127, 1'b0, 1'b0, 1'b0, 4'h0, "R3");
    step(2'b00, 2'b01, 7'd67, 1'b0, 1'b0, 1'b0, 4'h0, "R5");
    step(2'b10, 2'b10, 7'd5, 1'b0, 1'b1, 1'b0, 4'h0, "R5");
    // R8: save, then untaken call/jump/dispatch, return must give saved point
    step(2'b00, 2'b00, 7'd20, 1'b0, 1'b0, 1'b0, 4'h0, "R3");
    step(2'b00, 2'b01, 7'd90, 1'b0, 1'b0, 1'b0, 4'h0, "R5");
    step(2'b11, 2'b01, 7'd3, 1'b0, 1'b0, 1'b0, 4'h0, "R4");
    step(2'b00, 2'b00, 7'd44, 1'b0, 1'b0, 1'b0, 4'h0, "R3");
    step(2'b00, 2'b11, 7'd44, 1'b0, 1'b0, 1'b0, 4'h5, "R7");
    step(2'b11, 2'b10, 7'd77, 1'b1, 1'b1, 1'b1, 4'h0, "R8");
    // R7: opcode 0010 goes to 8 with noisy select and target
    step(2'b01, 2'b11, 7'd127, 1'b0, 1'b1, 1'b1, 4'h2, "R7");
    step(2'b11, 2'b11, 7'd0, 1'b1, 1'b1, 1'b1, 4'hF, "R7");
    // R6: return ignores select and target
    step(2'b10, 2'b10, 7'd127, 1'b0, 1'b0, 1'b0, 4'h9, "R6");
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[1:0], r[3:2], r[10:4], r[11], r[12], r[13], r[17:14], "");
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule